// File: doc/BRIEF.md
# Data Access Fault Status Unit

This unit sits after the data translation lookup of a load/store pipeline. Each request carries a virtual address, a load/store flag, the lookup result for that address (hit flag, physical page number, per-mode read and write enables, and the fault-on-read and fault-on-write bits), and the identifying parts of the instruction (opcode and destination register number). The unit decides whether the access may proceed. If it may, it returns the physical address. If not, it returns a fault type and builds a memory-management status word.

On a fault the unit also captures three values: the faulting address, the status word, and a formatted address that points into the page table. These capture registers are then locked. Later faults leave them untouched until software reads the fault-address register, which it signals with a one-cycle read strobe. Storage of the translation entries is outside this block.

Requests enter on a valid/ready interface. Results leave through a one-deep registered valid/ready output. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. While `res_valid` is high and `res_ready` is low, the result holds still and no new request is taken. The mode, enable, base-address and read-strobe pins are plain levels.

Top module: `dfault_unit`

## Requirements
- R1: The mode used for the permission check is selected as follows. Outside privileged-code state it is `cur_mode`. In privileged-code state it is `alt_mode` when `req_alt` is set, and kernel (0) otherwise. Mode codes are kernel=0, executive=1, supervisor=2, user=3, and mode m selects bit m of `tlb_rd_en`/`tlb_wr_en`.
- R2: An address whose bits 63:42 are not all equal is invalid. It gives fault type FAULT (2) with cause bits ACV and BADVA, plus WR for a store.
- R3: When `sp_enable` is set and address bits 42:41 equal 2'b10, the access is a superpage access and no lookup is used. If `cur_mode` is not kernel, it gives fault type ACV (1) with cause ACV, plus WR for a store. Otherwise the physical address is the low 44 address bits.
- R4: If a valid, non-superpage access has `tlb_hit` low, it gives cause MISS, plus WR for a store. The fault type is PTE_MISS (4) when `req_vpte` is set and MISS (3) otherwise.
- R5: A store whose write enable for the selected mode is clear gives FAULT with cause WR, ACV and FOW (FOW only when `tlb_fow` is set). A store that passes the enable check but has `tlb_fow` set gives FAULT with WR and FOW.
- R6: A load whose read enable for the selected mode is clear gives ACV with cause ACV, plus FOR when `tlb_for` is set. A load that passes the check but has `tlb_for` set gives FAULT with cause FOR only.
- R7: The status word is {opcode[5:0], dest[4:0], cause[5:0]}, so the opcode starts at bit 11 and the destination at bit 6. The cause bits are WR=0, ACV=1, FOR=2, FOW=3, MISS=4, BADVA=5.
- R8: On the edge that accepts a faulting request while the unit is unlocked, the unit captures `fault_va`, `mm_status` and `va_form` (`pt_base` OR (address bits 42:13 shifted left by 3)) and sets `fault_locked`. A fault accepted while locked changes none of them.
- R9: `fva_rd` clears the lock in the cycle it is high. A fault accepted in that same cycle is therefore captured and relocks the registers. With no fault, the lock is clear after the edge.
- R10: An access that passes its checks returns FT_NONE (0) with physical address {`tlb_ppn`, address bits 12:0}. A superpage access returns the address directly. Any fault returns a physical address of 0.
- R11: A result is presented one cycle after its request is accepted. It holds stable while `res_ready` is low, and no request is accepted during that time.
- R12: After reset, `res_valid`, `fault_locked` and all capture registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_va | input | 64 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_alt | input | 1 | Request asks for alternate mode |
| req_vpte | input | 1 | Request is a page-table-entry fetch |
| req_opcode | input | 6 | Instruction opcode |
| req_dest | input | 5 | Destination register number |
| cur_mode | input | 2 | Current data mode |
| alt_mode | input | 2 | Alternate mode |
| priv_state | input | 1 | Privileged-code state |
| sp_enable | input | 1 | Superpage mapping enabled |
| pt_base | input | 64 | Page-table base for the formatted address |
| tlb_hit | input | 1 | Lookup hit |
| tlb_ppn | input | 31 | Physical page number |
| tlb_rd_en | input | 4 | Per-mode read enables |
| tlb_wr_en | input | 4 | Per-mode write enables |
| tlb_for | input | 1 | Fault-on-read bit |
| tlb_fow | input | 1 | Fault-on-write bit |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes result |
| res_pa | output | 44 | Physical address (0 on a fault) |
| res_ftype | output | 3 | Fault type: 0 none, 1 ACV, 2 FAULT, 3 MISS, 4 PTE_MISS |
| fva_rd | input | 1 | Read strobe of the fault-address register |
| fault_va | output | 64 | Captured fault address |
| mm_status | output | 17 | Captured status word |
| va_form | output | 64 | Captured formatted address |
| fault_locked | output | 1 | Capture registers locked |

## Verification
Hit loads and stores in each mode, including privileged-code state with and without the alternate-mode request, tell the mode selection apart from a plain use of the current mode. Bad addresses, superpages outside kernel mode, misses with and without the entry-fetch flag, and the four combinations of enable clear/set with fault-on-read or fault-on-write each produce a distinct fault type and cause pattern. Back-to-back faults with and without the read strobe separate a lock that holds from one that releases in the strobe's own cycle. A stretch of hits under toggling `res_ready` confirms that stalled results keep their order and their values.

// File: rtl/dfault_pkg.sv
package dfault_pkg;
  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_EXEC = 2'd1,
    MODE_SUPV = 2'd2,
    MODE_USER = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    FT_NONE     = 3'd0,
    FT_ACV      = 3'd1,
    FT_FAULT    = 3'd2,
    FT_MISS     = 3'd3,
    FT_PTE_MISS = 3'd4
  } ftype_e;

  localparam int NCAUSE   = 6;
  localparam int CB_WR    = 0;
  localparam int CB_ACV   = 1;
  localparam int CB_FOR   = 2;
  localparam int CB_FOW   = 3;
  localparam int CB_MISS  = 4;
  localparam int CB_BADVA = 5;
endpackage

// File: rtl/dfault_mode_sel.sv
module dfault_mode_sel
  import dfault_pkg::*;
(
  input  logic [1:0] cur_mode,
  input  logic [1:0] alt_mode,
  input  logic       priv_state,
  input  logic       req_alt,
  output logic [1:0] eff_mode
);
  // R1: privileged code uses kernel or alternate mode
  always_comb begin
    if (!priv_state)  eff_mode = cur_mode;
    else if (req_alt) eff_mode = alt_mode;
    else              eff_mode = MODE_KERN;
  end
endmodule

// File: rtl/dfault_check.sv
module dfault_check
  import dfault_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int PG_BITS = 13,
  parameter int PA_W    = 44
) (
  input  logic [VA_W-1:0]         va,
  input  logic                    is_store,
  input  logic                    vpte,
  input  logic                    sp_enable,
  input  logic [1:0]              cur_mode,
  input  logic [1:0]              eff_mode,
  input  logic                    tlb_hit,
  input  logic [PA_W-PG_BITS-1:0] tlb_ppn,
  input  logic [3:0]              tlb_rd_en,
  input  logic [3:0]              tlb_wr_en,
  input  logic                    tlb_for,
  input  logic                    tlb_fow,
  output logic [PA_W-1:0]         pa,
  output logic [2:0]              ftype,
  output logic [NCAUSE-1:0]       cause
);
  localparam int HI_W = VA_W - VA_IMPL + 1;

  logic [HI_W-1:0] va_hi;
  logic            va_ok;
  logic            sp_hit;
  logic [PA_W-1:0] tlb_pa;

  assign va_hi  = va[VA_W-1:VA_IMPL-1];
  assign va_ok  = (&va_hi) | ~(|va_hi);
  assign sp_hit = sp_enable && (va[VA_IMPL-1 -: 2] == 2'b10);
  assign tlb_pa = {tlb_ppn, va[PG_BITS-1:0]};

  always_comb begin
    cause = '0;
    ftype = FT_NONE;
    pa    = '0;
    if (!va_ok) begin
      cause[CB_WR]    = is_store;
      cause[CB_ACV]   = 1'b1;
      cause[CB_BADVA] = 1'b1;
      ftype           = FT_FAULT;
    end else if (sp_hit) begin
      if (cur_mode != MODE_KERN) begin
        cause[CB_WR]  = is_store;
        cause[CB_ACV] = 1'b1;
        ftype         = FT_ACV;
      end else begin
        pa = va[PA_W-1:0];
      end
    end else if (!tlb_hit) begin
      cause[CB_WR]   = is_store;
      cause[CB_MISS] = 1'b1;
      ftype          = vpte ? FT_PTE_MISS : FT_MISS;
    end else if (is_store) begin
      if (!tlb_wr_en[eff_mode]) begin
        cause[CB_WR]  = 1'b1;
        cause[CB_ACV] = 1'b1;
        cause[CB_FOW] = tlb_fow;
        ftype         = FT_FAULT;
      end else if (tlb_fow) begin
        cause[CB_WR]  = 1'b1;
        cause[CB_FOW] = 1'b1;
        ftype         = FT_FAULT;
      end else begin
        pa = tlb_pa;
      end
    end else begin
      if (!tlb_rd_en[eff_mode]) begin
        cause[CB_ACV] = 1'b1;
        cause[CB_FOR] = tlb_for;
        ftype         = FT_ACV;
      end else if (tlb_for) begin
        cause[CB_FOR] = 1'b1;
        ftype         = FT_FAULT;
      end else begin
        pa = tlb_pa;
      end
    end
  end
endmodule

// File: rtl/dfault_regs.sv
module dfault_regs #(
  parameter int VA_W = 64,
  parameter int ST_W = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            fva_rd,
  input  logic [VA_W-1:0] va,
  input  logic [ST_W-1:0] status,
  input  logic [VA_W-1:0] form,
  output logic [VA_W-1:0] fault_va,
  output logic [ST_W-1:0] mm_status,
  output logic [VA_W-1:0] va_form,
  output logic            locked
);
  logic lock_held;
  logic capture;

  assign lock_held = locked & ~fva_rd;
  assign capture   = fire & ~lock_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_va  <= '0;
      mm_status <= '0;
      va_form   <= '0;
      locked    <= 1'b0;
    end else begin
      locked <= capture | lock_held;
      if (capture) begin
        fault_va  <= va;
        mm_status <= status;
        va_form   <= form;
      end
    end
  end

  // R8
  hold_while_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !fva_rd |=> $stable(fault_va) && $stable(mm_status) && $stable(va_form) && locked);
  // R8
  lock_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> locked);
  // R9
  unlock_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fva_rd && !fire |=> !locked);
endmodule

// File: rtl/dfault_unit.sv
module dfault_unit
  import dfault_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int PG_BITS = 13,
  parameter int PA_W    = 44,
  parameter int OPC_W   = 6,
  parameter int REG_W   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_va,
  input  logic                    req_store,
  input  logic                    req_alt,
  input  logic                    req_vpte,
  input  logic [OPC_W-1:0]        req_opcode,
  input  logic [REG_W-1:0]        req_dest,
  input  logic [1:0]              cur_mode,
  input  logic [1:0]              alt_mode,
  input  logic                    priv_state,
  input  logic                    sp_enable,
  input  logic [VA_W-1:0]         pt_base,
  input  logic                    tlb_hit,
  input  logic [PA_W-PG_BITS-1:0] tlb_ppn,
  input  logic [3:0]              tlb_rd_en,
  input  logic [3:0]              tlb_wr_en,
  input  logic                    tlb_for,
  input  logic                    tlb_fow,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic [PA_W-1:0]         res_pa,
  output logic [2:0]              res_ftype,
  input  logic                    fva_rd,
  output logic [VA_W-1:0]         fault_va,
  output logic [OPC_W+REG_W+NCAUSE-1:0] mm_status,
  output logic [VA_W-1:0]         va_form,
  output logic                    fault_locked
);
  localparam int ST_W  = OPC_W + REG_W + NCAUSE;
  localparam int VPN_W = VA_IMPL - PG_BITS;

  logic [1:0]        eff_mode;
  logic [PA_W-1:0]   chk_pa;
  logic [2:0]        chk_ftype;
  logic [NCAUSE-1:0] chk_cause;
  logic              accept;
  logic              fire;
  logic [ST_W-1:0]   status_word;
  logic [VA_W-1:0]   form_word;
  logic [VPN_W-1:0]  vpn;

  dfault_mode_sel u_mode (
    .cur_mode   (cur_mode),
    .alt_mode   (alt_mode),
    .priv_state (priv_state),
    .req_alt    (req_alt),
    .eff_mode   (eff_mode)
  );

  dfault_check #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PG_BITS(PG_BITS), .PA_W(PA_W)
  ) u_check (
    .va        (req_va),
    .is_store  (req_store),
    .vpte      (req_vpte),
    .sp_enable (sp_enable),
    .cur_mode  (cur_mode),
    .eff_mode  (eff_mode),
    .tlb_hit   (tlb_hit),
    .tlb_ppn   (tlb_ppn),
    .tlb_rd_en (tlb_rd_en),
    .tlb_wr_en (tlb_wr_en),
    .tlb_for   (tlb_for),
    .tlb_fow   (tlb_fow),
    .pa        (chk_pa),
    .ftype     (chk_ftype),
    .cause     (chk_cause)
  );

  assign req_ready   = !res_valid || res_ready;
  assign accept      = req_valid && req_ready;
  assign fire        = accept && (chk_ftype != FT_NONE);
  assign vpn         = req_va[VA_IMPL-1:PG_BITS];
  assign status_word = {req_opcode, req_dest, chk_cause};
  assign form_word   = pt_base | (VA_W'(vpn) << 3);

  dfault_regs #(.VA_W(VA_W), .ST_W(ST_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .fva_rd    (fva_rd),
    .va        (req_va),
    .status    (status_word),
    .form      (form_word),
    .fault_va  (fault_va),
    .mm_status (mm_status),
    .va_form   (va_form),
    .locked    (fault_locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_pa    <= '0;
      res_ftype <= FT_NONE;
    end else if (req_ready) begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_pa    <= chk_pa;
        res_ftype <= chk_ftype;
      end
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_pa) && $stable(res_ftype));
  // R10
  fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_ftype != FT_NONE) |-> res_pa == '0);
  // R4
  miss_not_acv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !(chk_cause[CB_MISS] && chk_cause[CB_ACV]));
  // R7
  clean_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (chk_ftype == FT_NONE) |-> chk_cause == '0);
endmodule

// File: tb/test_dfault_unit.sv
module test_dfault_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] t_va = '0;
  logic        t_st = 1'b0, t_alt = 1'b0, t_vpte = 1'b0, t_priv = 1'b0, t_sp = 1'b0;
  logic [5:0]  t_op = '0;
  logic [4:0]  t_dst = '0;
  logic [1:0]  t_cur = 2'd0, t_altm = 2'd0;
  logic [63:0] t_ptb = 64'h0000_0020_0000_0000;
  logic        t_hit = 1'b1;
  logic [30:0] t_ppn = '0;
  logic [3:0]  t_rde = 4'hF, t_wre = 4'hF;
  logic        t_for = 1'b0, t_fow = 1'b0;
  logic        t_rd = 1'b0;
  logic        res_valid, res_ready = 1'b1;
  logic [43:0] res_pa;
  logic [2:0]  res_ftype;
  logic [63:0] fault_va, va_form;
  logic [16:0] mm_status;
  logic        fault_locked;

  dfault_unit i_dfault_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(t_va), .req_store(t_st), .req_alt(t_alt), .req_vpte(t_vpte),
    .req_opcode(t_op), .req_dest(t_dst), .cur_mode(t_cur), .alt_mode(t_altm),
    .priv_state(t_priv), .sp_enable(t_sp), .pt_base(t_ptb), .tlb_hit(t_hit),
    .tlb_ppn(t_ppn), .tlb_rd_en(t_rde), .tlb_wr_en(t_wre), .tlb_for(t_for),
    .tlb_fow(t_fow), .res_valid(res_valid), .res_ready(res_ready),
    .res_pa(res_pa), .res_ftype(res_ftype), .fva_rd(t_rd), .fault_va(fault_va),
    .mm_status(mm_status), .va_form(va_form), .fault_locked(fault_locked)
  );

  typedef struct packed {
    logic [43:0] pa;
    logic [2:0]  ft;
    logic [63:0] fva;
    logic [16:0] st;
    logic [63:0] form;
    logic        lk;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    checks = 0, errors = 0, seq = 0;
  bit    bp_en = 1'b0, done = 1'b0;
  int    cyc = 0;
  exp_t  m_reg = '0;

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Expected outcome computed from the requirements.
  task automatic model(output logic [43:0] pa, output logic [2:0] ft, output logic [5:0] c);
    logic [1:0] m;
    logic ok;
    m  = t_priv ? (t_alt ? t_altm : 2'd0) : t_cur;               // R1
    ok = (&t_va[63:42]) | ~(|t_va[63:42]);                          // R2
    pa = '0; ft = 3'd0; c = '0;
    if (!ok) begin c = {1'b1, 3'b000, 1'b1, t_st}; ft = 3'd2; end
    else if (t_sp && t_va[42:41] == 2'b10) begin                    // R3
      if (t_cur != 2'd0) begin c = {4'b0000, 1'b1, t_st}; ft = 3'd1; end
      else pa = t_va[43:0];
    end else if (!t_hit) begin                                      // R4
      c = {1'b0, 1'b1, 3'b000, t_st}; ft = t_vpte ? 3'd4 : 3'd3;
    end else if (t_st) begin                                        // R5
      if (!t_wre[m]) begin c = {2'b00, t_fow, 1'b0, 2'b11}; ft = 3'd2; end
      else if (t_fow) begin c = 6'b001001; ft = 3'd2; end
      else pa = {t_ppn, t_va[12:0]};
    end else begin                                                  // R6
      if (!t_rde[m]) begin c = {3'b000, t_for, 2'b10}; ft = 3'd1; end
      else if (t_for) begin c = 6'b000100; ft = 3'd2; end
      else pa = {t_ppn, t_va[12:0]};
    end
  endtask

  // Driver: called right after a falling edge.
  task automatic send(input string tag);
    logic [43:0] pa;
    logic [2:0]  ft;
    logic [5:0]  c;
    logic        held;
    exp_t        e;
    seq++;
    t_op  = 6'(seq * 7 + 3);
    t_dst = 5'(seq * 5 + 1);
    model(pa, ft, c);
    req_valid = 1'b1;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    held = m_reg.lk & ~t_rd;                                        // R9
    if (ft != 3'd0 && !held) begin                                  // R8
      m_reg.fva  = t_va;
      m_reg.st   = {t_op, t_dst, c};                                // R7
      m_reg.form = t_ptb | ({34'd0, t_va[42:13]} << 3);
    end
    m_reg.lk = (ft != 3'd0 && !held) | held;
    e = m_reg;
    e.pa = pa;
    e.ft = ft;
    expq.push_back(e);
    tagq.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
    t_rd = 1'b0;
  endtask

  task automatic defaults;
    t_va = 64'h0000_0001_2345_6789; t_st = 0; t_alt = 0; t_vpte = 0; t_priv = 0;
    t_sp = 0; t_cur = 2'd0; t_altm = 2'd0; t_hit = 1; t_ppn = 31'h1234_5678;
    t_rde = 4'hF; t_wre = 4'hF; t_for = 0; t_fow = 0; t_rd = 0;
  endtask

  // Monitor and back-pressure in one process to keep a single order.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && res_valid && res_ready) begin
      exp_t  e;
      string tg;
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected result pa=%h ft=%0d expected none", res_pa, res_ftype);
      end else begin
        e  = expq.pop_front();
        tg = tagq.pop_front();
        checks++;
        if (res_pa !== e.pa || res_ftype !== e.ft || fault_va !== e.fva ||
            mm_status !== e.st || va_form !== e.form || fault_locked !== e.lk) begin
          errors++;
          $display("FAIL %s pa=%h ft=%0d fva=%h st=%h form=%h lk=%b expected pa=%h ft=%0d fva=%h st=%h form=%h lk=%b",
                   tg, res_pa, res_ftype, fault_va, mm_status, va_form, fault_locked,
                   e.pa, e.ft, e.fva, e.st, e.form, e.lk);
        end
      end
    end
    res_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired, pending=%0d expected 0", expq.size());
      report();
    end
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    checks++;
    if (res_valid !== 1'b0 || fault_locked !== 1'b0 || fault_va !== '0 || mm_status !== '0 || va_form !== '0) begin
      errors++;
      $display("FAIL R12 valid=%b lk=%b fva=%h st=%h expected all zero", res_valid, fault_locked, fault_va, mm_status);
    end

    defaults(); send("R10 hit load");
    defaults(); t_sp = 1; t_va = 64'hFFFF_FC00_0000_1234; send("R10 superpage kernel");
    defaults(); t_st = 1; t_cur = 2'd3; t_wre = 4'b1000; send("R1 store current user mode");
    defaults(); t_sp = 1; t_va = 64'hFFFF_FC00_0000_1234; t_cur = 2'd2; t_st = 1; send("R3 superpage non-kernel");
    defaults(); t_va = 64'h0100_0000_0000_0000; send("R8 bad address while locked");
    defaults(); t_va = 64'h0100_0000_0000_0000; t_st = 1; t_rd = 1; send("R2 bad address store, R9 read same cycle");
    defaults(); t_hit = 0; t_st = 1; t_rd = 1; send("R4 ordinary miss store");
    defaults(); t_hit = 0; t_vpte = 1; t_rd = 1; send("R4 entry-fetch miss load");
    defaults(); t_st = 1; t_wre = 4'b1110; t_fow = 1; t_rd = 1; send("R5 store enable clear with fow");
    defaults(); t_st = 1; t_wre = 4'b1110; t_rd = 1; send("R5 store enable clear");
    defaults(); t_st = 1; t_fow = 1; t_rd = 1; send("R5 store fow only");
    defaults(); t_rde = 4'b0110; t_for = 1; t_rd = 1; send("R6 load enable clear with for");
    defaults(); t_for = 1; t_rd = 1; send("R6 load for only, R7 packing");
    defaults(); t_rd = 1; send("R9 read strobe without fault");
    defaults(); t_priv = 1; t_alt = 1; t_altm = 2'd3; t_rde = 4'b1000; send("R1 privileged alternate mode pass");
    defaults(); t_priv = 1; t_alt = 1; t_altm = 2'd3; t_rde = 4'b0001; send("R1 privileged alternate mode fail");
    defaults(); t_priv = 1; t_cur = 2'd3; t_rde = 4'b0001; t_rd = 1; send("R1 privileged kernel pass");
    defaults(); t_cur = 2'd2; t_rde = 4'b0100; send("R1 supervisor pass");
    defaults(); t_cur = 2'd2; t_rde = 4'b1011; t_rd = 1; send("R1 supervisor fail");

    bp_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      defaults();
      t_va  = 64'h0000_0000_0000_0000 | (64'(i) << 13) | 64'(i * 97);
      t_ppn = 31'(i * 1009 + 5);
      t_st  = i[0];
      send("R11 stream under back-pressure");
    end
    bp_en = 1'b0;
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule